// File: doc/BRIEF.md
# Compare-flag and conditional-branch unit

This block sits beside the integer datapath of a small 32-bit core. A compare strobe carries two register values. The block compares them once and stores the result as a five-bit condition code. The code keeps equality apart from the signed and unsigned less-than and greater-than outcomes, so that later branches can test either signedness without repeating the compare.

A branch strobe carries a 4-bit condition selector, the address of the branch instruction and a 10-bit halfword offset. The block tests the stored code against the selected condition and returns three results one cycle later: a taken flag, the next program counter and an illegal-condition flag. Instructions are two bytes long. The fall-through address is therefore the branch address plus 2, and a taken branch adds the displacement on top of that.

A compare and a branch that arrive in the same cycle are both rejected. The block raises a collision flag for that cycle.

Top module: `cmpbr_unit`

## Requirements
- R1: Reset clears the stored condition code and all result outputs. A branch issued before any compare therefore finds equality clear: selector 0 is not taken and selector 1 is taken.
- R2: An accepted compare recomputes all five stored flags from the two operands. The flags are equal; signed less-than and signed greater-than (two's complement); unsigned less-than and unsigned greater-than.
- R3: The stored condition code keeps its value when no compare is accepted. This holds through idle cycles and through any number of branches.
- R4: Selectors 0 to 5 are taken, in that order, on: equal, not equal, signed less-than, signed greater-than, unsigned less-than, unsigned greater-than.
- R5: Selectors 6 to 9 are taken, in that order, on: signed greater-than or equal, signed less-than or equal, unsigned greater-than or equal, unsigned less-than or equal.
- R6: Selectors 10 to 15 are illegal. The result reports illegal set, taken clear and next PC equal to the branch address plus 2. Selectors 0 to 9 report illegal clear.
- R7: For a taken branch, the next PC is the branch address plus 2 plus the 10-bit offset, sign-extended and shifted left by one. Offset 0x1FF adds 1022 and offset 0x200 subtracts 1024, both before the +2. The sum wraps modulo 2^32.
- R8: For a branch that is not taken, the next PC is the branch address plus 2.
- R9: When the compare and branch strobes are both high in one cycle, `collide_o` pulses for one cycle, no branch result is produced and the stored condition code is left unchanged.
- R10: An accepted branch produces `br_done_o` for exactly one cycle, in the cycle after its strobe. Taken, next PC and illegal are valid in that cycle and hold until the next accepted branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | Compare strobe |
| cmp_a_i | input | 32 | First compare operand |
| cmp_b_i | input | 32 | Second compare operand |
| br_valid_i | input | 1 | Branch strobe |
| br_cond_i | input | 4 | Branch condition selector |
| br_pc_i | input | 32 | Address of the branch instruction |
| br_ofs_i | input | 10 | Signed halfword offset |
| br_done_o | output | 1 | Branch result valid, one-cycle pulse |
| br_taken_o | output | 1 | Branch was taken |
| br_next_pc_o | output | 32 | Next program counter |
| br_illegal_o | output | 1 | Selector was illegal |
| collide_o | output | 1 | Compare and branch arrived together and were rejected |

## Verification
Compares and branches are the two operations that can share a cycle. The bench provokes this by raising both strobes with a compare whose operands differ from those of the last accepted compare. It expects a `collide_o` pulse and no `br_done_o` pulse in the following cycle. It then issues a lone branch that depends on equality, and its outcome shows that the colliding compare never reached the stored flags. Every result pulse is matched, including the cycle it appears in, against a queue of expected items computed from a bench-side flag model.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

  localparam int unsigned CC_W = 5;

  typedef struct packed {
    logic gtu;
    logic ltu;
    logic gt;
    logic lt;
    logic eq;
  } cc_t;

  // selector values decoded by the branch evaluator
  typedef enum logic [3:0] {
    SEL_EQ  = 4'd0,
    SEL_NE  = 4'd1,
    SEL_LT  = 4'd2,
    SEL_GT  = 4'd3,
    SEL_LTU = 4'd4,
    SEL_GTU = 4'd5,
    SEL_GE  = 4'd6,
    SEL_LE  = 4'd7,
    SEL_GEU = 4'd8,
    SEL_LEU = 4'd9
  } sel_e;

endpackage

// File: rtl/cmpbr_flag_calc.sv
module cmpbr_flag_calc
  import cmpbr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output cc_t             cc_o
);

  always_comb begin
    cc_o.eq  = (a_i == b_i);
    cc_o.lt  = ($signed(a_i) < $signed(b_i));
    cc_o.gt  = ($signed(a_i) > $signed(b_i));
    cc_o.ltu = (a_i < b_i);
    cc_o.gtu = (a_i > b_i);
  end

endmodule

// File: rtl/cmpbr_cond_eval.sv
module cmpbr_cond_eval
  import cmpbr_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  cc_t              cc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o,
  output logic             illegal_o
);

  localparam int unsigned NUM_LEGAL = 10;

  always_comb begin
    hit_o     = 1'b0;
    illegal_o = (sel_i >= SEL_W'(NUM_LEGAL));
    if (!illegal_o) begin
      case (sel_i[3:0])
        SEL_EQ:  hit_o = cc_i.eq;
        SEL_NE:  hit_o = ~cc_i.eq;
        SEL_LT:  hit_o = cc_i.lt;
        SEL_GT:  hit_o = cc_i.gt;
        SEL_LTU: hit_o = cc_i.ltu;
        SEL_GTU: hit_o = cc_i.gtu;
        SEL_GE:  hit_o = cc_i.gt  | cc_i.eq;
        SEL_LE:  hit_o = cc_i.lt  | cc_i.eq;
        SEL_GEU: hit_o = cc_i.gtu | cc_i.eq;
        SEL_LEU: hit_o = cc_i.ltu | cc_i.eq;
        default: hit_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cmpbr_pc_calc.sv
module cmpbr_pc_calc #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFS_W = 10,
  parameter int unsigned STEP  = 2
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             taken_i,
  output logic [XLEN-1:0]  next_pc_o
);

  localparam int unsigned DISP_W = OFS_W + 1;

  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] addend;

  generate
    if (XLEN > DISP_W) begin : g_sext
      assign disp = {{(XLEN-DISP_W){ofs_i[OFS_W-1]}}, ofs_i, 1'b0};
    end else begin : g_trunc
      logic [DISP_W-1:0] wide;
      assign wide = {ofs_i, 1'b0};
      assign disp = wide[XLEN-1:0];
    end
  endgenerate

  // one adder: the mux picks the addend, not the sum
  assign addend    = taken_i ? (disp + XLEN'(STEP)) : XLEN'(STEP);
  assign next_pc_o = pc_i + addend;

endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
  import cmpbr_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned OFS_W = 10,
  parameter int unsigned STEP  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_valid_i,
  input  logic [XLEN-1:0]  cmp_a_i,
  input  logic [XLEN-1:0]  cmp_b_i,
  input  logic             br_valid_i,
  input  logic [SEL_W-1:0] br_cond_i,
  input  logic [XLEN-1:0]  br_pc_i,
  input  logic [OFS_W-1:0] br_ofs_i,
  output logic             br_done_o,
  output logic             br_taken_o,
  output logic [XLEN-1:0]  br_next_pc_o,
  output logic             br_illegal_o,
  output logic             collide_o
);

  cc_t             cc_q;
  cc_t             cc_new;
  logic            cmp_go, br_go, clash;
  logic            hit, illegal;
  logic [XLEN-1:0] npc;

  assign clash  = cmp_valid_i & br_valid_i;
  assign cmp_go = cmp_valid_i & ~br_valid_i;
  assign br_go  = br_valid_i & ~cmp_valid_i;

  cmpbr_flag_calc #(.XLEN(XLEN)) u_flag (
    .a_i (cmp_a_i),
    .b_i (cmp_b_i),
    .cc_o(cc_new)
  );

  cmpbr_cond_eval #(.SEL_W(SEL_W)) u_cond (
    .cc_i     (cc_q),
    .sel_i    (br_cond_i),
    .hit_o    (hit),
    .illegal_o(illegal)
  );

  cmpbr_pc_calc #(.XLEN(XLEN), .OFS_W(OFS_W), .STEP(STEP)) u_pc (
    .pc_i     (br_pc_i),
    .ofs_i    (br_ofs_i),
    .taken_i  (hit),
    .next_pc_o(npc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q <= '0;
    end else if (cmp_go) begin
      cc_q <= cc_new;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      br_done_o    <= 1'b0;
      br_taken_o   <= 1'b0;
      br_next_pc_o <= '0;
      br_illegal_o <= 1'b0;
      collide_o    <= 1'b0;
    end else begin
      br_done_o <= br_go;
      collide_o <= clash;
      if (br_go) begin
        br_taken_o   <= hit;
        br_next_pc_o <= npc;
        br_illegal_o <= illegal;
      end
    end
  end

  p_eq_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_q.eq |-> !(cc_q.lt || cc_q.gt || cc_q.ltu || cc_q.gtu));

  p_order_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cc_q.lt, cc_q.gt}) && $onehot0({cc_q.ltu, cc_q.gtu}));

  p_cc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmp_valid_i && !br_valid_i) |=> $stable(cc_q));

  p_illegal_not_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_illegal_o |-> !br_taken_o);

  p_fallthrough_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !cmp_valid_i) ##1 !br_taken_o |->
      br_next_pc_o == $past(br_pc_i) + XLEN'(STEP));

  p_collide_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && br_valid_i) |=> (collide_o && !br_done_o));

  p_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !cmp_valid_i) |=> br_done_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> !br_done_o);

endmodule

// File: tb/cmpbr_unit_tb.sv
module cmpbr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [31:0] br_pc = '0;
  logic [9:0]  br_ofs = '0;
  logic        done, taken, illegal, collide;
  logic [31:0] next_pc;

  always #2 clk = ~clk;

  cmpbr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmp_valid_i(cmp_valid), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
    .br_valid_i(br_valid), .br_cond_i(br_cond), .br_pc_i(br_pc), .br_ofs_i(br_ofs),
    .br_done_o(done), .br_taken_o(taken), .br_next_pc_o(next_pc),
    .br_illegal_o(illegal), .collide_o(collide)
  );

  typedef struct {
    bit          coll;
    bit          tk;
    bit          ill;
    logic [31:0] pc;
    int          cyc;
    string       ctx;
  } item_t;

  item_t q[$];
  int total = 0, fails = 0, cyc = 0;
  bit m_eq = 0, m_lt = 0, m_gt = 0, m_ltu = 0, m_gtu = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit model_take(input logic [3:0] c);
    case (c)
      4'd0: return m_eq;
      4'd1: return !m_eq;
      4'd2: return m_lt;
      4'd3: return m_gt;
      4'd4: return m_ltu;
      4'd5: return m_gtu;
      4'd6: return m_gt | m_eq;
      4'd7: return m_lt | m_eq;
      4'd8: return m_gtu | m_eq;
      4'd9: return m_ltu | m_eq;
      default: return 0;
    endcase
  endfunction

  function automatic string grp(input logic [3:0] c);
    if (c < 6) return "R4";
    if (c < 10) return "R5";
    return "R6";
  endfunction

  // drive one cycle of stimulus and queue what it should produce
  task automatic drive(input bit cv, input logic [31:0] a, input logic [31:0] b,
                       input bit bv, input logic [3:0] c, input logic [31:0] pc,
                       input logic [9:0] ofs, input string ctx);
    item_t it;
    @(negedge clk);
    cmp_valid = cv; cmp_a = a; cmp_b = b;
    br_valid = bv; br_cond = c; br_pc = pc; br_ofs = ofs;
    it.cyc = cyc + 1;
    it.ctx = ctx;
    if (cv && bv) begin
      it.coll = 1; it.tk = 0; it.ill = 0; it.pc = '0;
      q.push_back(it);
    end else if (bv) begin
      it.coll = 0;
      it.ill  = (c >= 10);
      it.tk   = model_take(c);
      it.pc   = pc + 32'd2 + (it.tk ? {{21{ofs[9]}}, ofs, 1'b0} : 32'd0);
      q.push_back(it);
    end else if (cv) begin
      m_eq  = (a == b);
      m_lt  = ($signed(a) < $signed(b));
      m_gt  = ($signed(a) > $signed(b));
      m_ltu = (a < b);
      m_gtu = (a > b);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cmp_valid = 0; br_valid = 0;
  endtask

  task automatic sweep(input logic [31:0] pc, input logic [9:0] ofs, input string ctx);
    for (int c = 0; c < 16; c++) drive(0, 0, 0, 1, 4'(c), pc + 32'(c * 8), ofs, ctx);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (done || collide)) begin
      if (q.size() == 0) begin
        chk(0, "R10 unexpected result", {30'd0, done, collide}, 32'd0);
      end else begin
        item_t e;
        e = q.pop_front();
        chk(cyc == e.cyc, {e.ctx, " R10 latency"}, 32'(cyc), 32'(e.cyc));
        if (e.coll) begin
          chk(collide && !done, {e.ctx, " R9 collide"}, {30'd0, collide, done}, 32'd2);
        end else begin
          chk(done && !collide, {e.ctx, " R10 done"}, {30'd0, done, collide}, 32'd2);
          chk(taken == e.tk, {e.ctx, " ", grp(br_cond), " taken"}, 32'(taken), 32'(e.tk));
          chk(illegal == e.ill, {e.ctx, " R6 illegal"}, 32'(illegal), 32'(e.ill));
          chk(next_pc == e.pc, {e.ctx, e.tk ? " R7 pc" : " R8 pc"}, next_pc, e.pc);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    chk(!done && !taken && !illegal && !collide && next_pc == 0, "R1 outputs",
        {next_pc[27:0], done, taken, illegal, collide}, 32'd0);
    rst_n = 1;
    drive(0, 0, 0, 1, 4'd0, 32'h100, 10'h004, "R1");
    drive(0, 0, 0, 1, 4'd1, 32'h100, 10'h004, "R1");
    drive(1, 32'd5, 32'd5, 0, 0, 0, 0, "R2");
    sweep(32'h0000_1000, 10'h1FF, "R2 eq");
    drive(1, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, "R2");
    sweep(32'h0000_2000, 10'h200, "R2 neg");
    idle(); idle(); idle();
    // R3: flags hold across idle cycles
    drive(0, 0, 0, 1, 4'd2, 32'h3000, 10'h3FF, "R3");
    drive(0, 0, 0, 1, 4'd5, 32'h3000, 10'h3FF, "R3");
    drive(1, 32'd1, 32'h8000_0000, 0, 0, 0, 0, "R2");
    sweep(32'hFFFF_FFF0, 10'h010, "R2 wrap");
    drive(1, 32'd9, 32'd3, 0, 0, 0, 0, "R2");
    // R9: colliding compare of equal values must not reach the flags
    drive(1, 32'd7, 32'd7, 1, 4'd0, 32'h4000, 10'h001, "R9");
    drive(0, 0, 0, 1, 4'd0, 32'h4000, 10'h001, "R9");
    drive(0, 0, 0, 1, 4'd8, 32'h4000, 10'h001, "R9");
    drive(1, 32'd3, 32'd9, 0, 0, 0, 0, "R2");
    drive(0, 0, 0, 1, 4'd9, 32'h0000_0010, 10'h200, "R7");
    drive(0, 0, 0, 1, 4'd15, 32'h5000, 10'h0FF, "R6");
    drive(0, 0, 0, 1, 4'd10, 32'h5000, 10'h0FF, "R6");
    idle();
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10 pending results", 32'(q.size()), 32'd0);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule